// File: doc/BRIEF.md
# Dual-Counter Performance Monitor

The block counts processor events in two 32-bit counters that share one 64-bit counter register. Counter 0 sits in the upper half and counter 1 in the lower half. A single 64-bit control register holds one event-select field per counter. It also holds three privilege-context enables and an interrupt enable. The three context enables are shared by both counters, so one counter cannot be stopped on its own. Software idles a counter instead by giving it an event code whose source almost never strobes.

Each cycle, a counter adds one when its selected event strobes and the enable for the current privilege level is set. The same event code can mean different things on the two counters: code 0x09 counts cache misses on the upper counter and cache references on the lower counter. When a counter wraps from all ones to zero, it sets a sticky flag. The level interrupt output is the OR of the flags, gated by the interrupt enable. Software clears a flag by writing 1 to it.

Software reaches the block through a simple register port. Writes are word-wide for the control register and per half for the counter register. Reads are registered.

Top module: `pmu_dual_counter`

## Requirements
- R1: After a synchronous reset, both counters, the control register, both flags, `reg_rdata` and `irq` are zero.
- R2: When `reg_sel`=1 the counter register is addressed. Counter 0 occupies bits [63:32] and counter 1 occupies bits [31:0]. `reg_half[1]` writes the upper half and `reg_half[0]` writes the lower half. A half that is not strobed is left unchanged by the write.
- R3: Event code 0x00 counts every qualified cycle and code 0x01 counts cycles with `ev_in[0]` (retired instruction) high. Both codes behave the same on either counter.
- R4: Event code 0x09 counts `ev_in[2]` (cache miss) on the upper counter and `ev_in[1]` (cache reference) on the lower counter.
- R5: Code 0x1C on the upper counter and code 0x14 on the lower counter count `ev_in[3]`, a rarely firing marker strobe. Every other code counts nothing, including 0x14 on the upper counter and 0x1C on the lower counter.
- R6: Counting requires the context enable that matches `priv_lvl`. `priv_lvl` 0 is user, gated by control bit 2. `priv_lvl` 1 is supervisor, gated by bit 1. `priv_lvl` 2 is hypervisor, gated by bit 3. `priv_lvl` 3 never counts. The enables apply to both counters.
- R7: A write to a counter half in the same cycle as an increment of that counter loads the written value. The increment is dropped, and the write never sets that counter's flag.
- R8: An increment from 0xFFFFFFFF to 0 sets a sticky flag: control bit 18 for the upper counter and bit 17 for the lower counter. The event-select fields sit at bits [16:11] (upper counter) and [9:4] (lower counter).
- R9: `irq` is high exactly when control bit 0 (interrupt enable) is set and at least one flag is set. It follows the same clock edge that updates them.
- R10: A control write with 1 in a flag bit clears that flag, and 0 leaves it unchanged. A wrap in the same cycle as the clear keeps the flag set.
- R11: A read (`reg_rd`) returns the addressed register as it stood in the read cycle, on `reg_rdata` one cycle later. `reg_rdata` holds otherwise. Control bits outside 0-9, 11-18 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 1 | 0 selects the control register, 1 selects the counter register |
| reg_half | input | 2 | Counter-half write strobes: bit 1 upper, bit 0 lower |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Registered read data |
| ev_in | input | 4 | Event strobes: retired, cache reference, cache miss, marker |
| priv_lvl | input | 2 | Current privilege level |
| irq | output | 1 | Overflow interrupt level |

## Verification
The assertions assume that `priv_lvl` and `ev_in` are valid in every cycle. They also assume that the control write data is the only thing that can clear a flag, so a wrap in the same cycle as a write-one-to-clear must still leave the flag set. The stimulus never asserts `reg_rd` and `reg_wr` in the same cycle. Counters are preloaded next to 0xFFFFFFFF so that wraps, and collisions between a wrap and a clear or a write, happen within a few cycles. Event codes in the random phase are drawn mostly from the codes that count something, so counting is actually exercised.

// File: rtl/pmu_pkg.sv
`timescale 1ns/1ps
package pmu_pkg;
  localparam int SEL_W  = 6;
  localparam int NUM_EV = 4;

  // control register bit positions
  localparam int IRQ_BIT    = 0;
  localparam int SUP_BIT    = 1;
  localparam int USR_BIT    = 2;
  localparam int HYP_BIT    = 3;
  localparam int SEL_LO_LSB = 4;
  localparam int SEL_HI_LSB = 11;
  localparam int FLG_LO_BIT = 17;
  localparam int FLG_HI_BIT = 18;

  // event strobe indices
  localparam int EV_RETIRED = 0;
  localparam int EV_CREF    = 1;
  localparam int EV_CMISS   = 2;
  localparam int EV_MARK    = 3;

  // event codes
  localparam logic [SEL_W-1:0] EVC_CYCLES  = 6'h00;
  localparam logic [SEL_W-1:0] EVC_RETIRED = 6'h01;
  localparam logic [SEL_W-1:0] EVC_CACHE   = 6'h09;
  localparam logic [SEL_W-1:0] EVC_IDLE_HI = 6'h1C;
  localparam logic [SEL_W-1:0] EVC_IDLE_LO = 6'h14;

  typedef enum logic [1:0] {
    PRIV_USER = 2'd0,
    PRIV_SUP  = 2'd1,
    PRIV_HYP  = 2'd2,
    PRIV_NONE = 2'd3
  } priv_e;

  typedef struct packed {
    logic [SEL_W-1:0] sel_hi;
    logic [SEL_W-1:0] sel_lo;
    logic             en_hyp;
    logic             en_usr;
    logic             en_sup;
    logic             irq_en;
  } ctrl_t;
endpackage

// File: rtl/pmu_event_sel.sv
`timescale 1ns/1ps
// Per-counter event decode; UPPER picks the counter-dependent meanings.
module pmu_event_sel
  import pmu_pkg::*;
#(
  parameter bit UPPER = 1'b1
) (
  input  logic [SEL_W-1:0]  sel,
  input  logic [NUM_EV-1:0] ev,
  output logic              hit
);
  logic             cache_src;
  logic [SEL_W-1:0] idle_code;

  generate
    if (UPPER) begin : g_hi
      assign cache_src = ev[EV_CMISS];   // R4
      assign idle_code = EVC_IDLE_HI;    // R5
    end else begin : g_lo
      assign cache_src = ev[EV_CREF];    // R4
      assign idle_code = EVC_IDLE_LO;    // R5
    end
  endgenerate

  always_comb begin
    case (sel)
      EVC_CYCLES:  hit = 1'b1;
      EVC_RETIRED: hit = ev[EV_RETIRED];
      EVC_CACHE:   hit = cache_src;
      default:     hit = (sel == idle_code) & ev[EV_MARK];
    endcase
  end
endmodule

// File: rtl/pmu_ctx_gate.sv
`timescale 1ns/1ps
// Shared privilege-context qualification (R6).
module pmu_ctx_gate
  import pmu_pkg::*;
(
  input  logic [1:0] priv,
  input  logic       en_usr,
  input  logic       en_sup,
  input  logic       en_hyp,
  output logic       ok
);
  always_comb begin
    case (priv_e'(priv))
      PRIV_USER: ok = en_usr;
      PRIV_SUP:  ok = en_sup;
      PRIV_HYP:  ok = en_hyp;
      default:   ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/pmu_cnt_slice.sv
`timescale 1ns/1ps
// One counter: load beats increment, wrap reported combinationally.
module pmu_cnt_slice #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  localparam logic [W-1:0] ONE = W'(1);

  assign wrap = inc & ~ld & (&cnt);

  always_ff @(posedge clk) begin
    if (rst)      cnt <= '0;
    else if (ld)  cnt <= ld_val;
    else if (inc) cnt <= cnt + ONE;
  end

  assert_load_wins_R7: assert property (@(posedge clk) disable iff (rst)
    ld |=> cnt == $past(ld_val));
  assert_step_R3: assert property (@(posedge clk) disable iff (rst)
    (!ld && inc) |=> cnt == $past(cnt) + ONE);
  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!ld && !inc) |=> $stable(cnt));
endmodule

// File: rtl/pmu_dual_counter.sv
`timescale 1ns/1ps
module pmu_dual_counter
  import pmu_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic                 reg_sel,
  input  logic [1:0]           reg_half,
  input  logic [2*CNT_W-1:0]   reg_wdata,
  output logic [2*CNT_W-1:0]   reg_rdata,
  input  logic [NUM_EV-1:0]    ev_in,
  input  logic [1:0]           priv_lvl,
  output logic                 irq
);
  localparam int REG_W   = 2 * CNT_W;
  localparam int NUM_CNT = 2;

  logic               ctrl_wr, cnt_wr, ctx_ok;
  ctrl_t              ctrl_q, ctrl_d;
  logic [NUM_CNT-1:0] flag_q, flag_d, wrap, hit, ld;
  logic [CNT_W-1:0]   cnt [NUM_CNT];
  logic [REG_W-1:0]   ctrl_view;

  assign ctrl_wr = reg_wr & ~reg_sel;
  assign cnt_wr  = reg_wr &  reg_sel;

  pmu_ctx_gate u_ctx (
    .priv   (priv_lvl),
    .en_usr (ctrl_q.en_usr),
    .en_sup (ctrl_q.en_sup),
    .en_hyp (ctrl_q.en_hyp),
    .ok     (ctx_ok)
  );

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_wr) begin
      ctrl_d.sel_hi = reg_wdata[SEL_HI_LSB +: SEL_W];
      ctrl_d.sel_lo = reg_wdata[SEL_LO_LSB +: SEL_W];
      ctrl_d.en_hyp = reg_wdata[HYP_BIT];
      ctrl_d.en_usr = reg_wdata[USR_BIT];
      ctrl_d.en_sup = reg_wdata[SUP_BIT];
      ctrl_d.irq_en = reg_wdata[IRQ_BIT];
    end
  end

  // index 0 = upper half, index 1 = lower half (R2)
  generate
    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
      localparam int HALF = NUM_CNT - 1 - i;
      localparam int FLG  = (i == 0) ? FLG_HI_BIT : FLG_LO_BIT;

      logic [SEL_W-1:0] sel;
      assign sel = (i == 0) ? ctrl_q.sel_hi : ctrl_q.sel_lo;

      pmu_event_sel #(.UPPER(i == 0)) u_sel (
        .sel (sel),
        .ev  (ev_in),
        .hit (hit[i])
      );

      assign ld[i] = cnt_wr & reg_half[HALF];

      pmu_cnt_slice #(.W(CNT_W)) u_slice (
        .clk    (clk),
        .rst    (rst),
        .ld     (ld[i]),
        .ld_val (reg_wdata[HALF*CNT_W +: CNT_W]),
        .inc    (hit[i] & ctx_ok),
        .cnt    (cnt[i]),
        .wrap   (wrap[i])
      );

      // sticky flag, set wins over write-one-clear (R8, R10)
      assign flag_d[i] = wrap[i] | (flag_q[i] & ~(ctrl_wr & reg_wdata[FLG]));

      assert_wrap_sets_R8: assert property (@(posedge clk) disable iff (rst)
        wrap[i] |=> flag_q[i]);
      assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (flag_q[i] && !(ctrl_wr && reg_wdata[FLG])) |=> flag_q[i]);
      assert_w1c_R10: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && reg_wdata[FLG] && !wrap[i]) |=> !flag_q[i]);
    end
  endgenerate

  always_comb begin
    ctrl_view = '0;
    ctrl_view[IRQ_BIT]                = ctrl_q.irq_en;
    ctrl_view[SUP_BIT]                = ctrl_q.en_sup;
    ctrl_view[USR_BIT]                = ctrl_q.en_usr;
    ctrl_view[HYP_BIT]                = ctrl_q.en_hyp;
    ctrl_view[SEL_LO_LSB +: SEL_W]    = ctrl_q.sel_lo;
    ctrl_view[SEL_HI_LSB +: SEL_W]    = ctrl_q.sel_hi;
    ctrl_view[FLG_LO_BIT]             = flag_q[1];
    ctrl_view[FLG_HI_BIT]             = flag_q[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      flag_q    <= '0;
      irq       <= 1'b0;
      reg_rdata <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      flag_q <= flag_d;
      irq    <= ctrl_d.irq_en & (|flag_d);
      if (reg_rd) reg_rdata <= reg_sel ? {cnt[0], cnt[1]} : ctrl_view;
    end
  end

  assert_irq_level_R9: assert property (@(posedge clk) disable iff (rst)
    irq == (ctrl_q.irq_en & (|flag_q)));
  assert_no_ctx_R6: assert property (@(posedge clk) disable iff (rst)
    (priv_lvl == 2'd3 && !cnt_wr) |=> ($stable(cnt[0]) && $stable(cnt[1])));
  assert_lower_half_R2: assert property (@(posedge clk) disable iff (rst)
    (cnt_wr && reg_half[0]) |=> cnt[1] == $past(reg_wdata[CNT_W-1:0]));
  assert_read_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> $stable(reg_rdata));
endmodule

// File: tb/tb_pmu_dual_counter.sv
`timescale 1ns/1ps
module tb_pmu_dual_counter;
  logic        clk = 1'b0;
  logic        rst, reg_wr, reg_rd, reg_sel;
  logic [1:0]  reg_half;
  logic [63:0] reg_wdata, reg_rdata;
  logic [3:0]  ev_in;
  logic [1:0]  priv_lvl;
  logic        irq;

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 1'b0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  pmu_dual_counter dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
    .reg_half(reg_half), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ev_in(ev_in), .priv_lvl(priv_lvl), .irq(irq)
  );

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_cnt [2];
  logic [5:0]  m_sel [2];
  logic        m_flag [2];
  logic        m_irq_en, m_sup, m_usr, m_hyp, m_irqo;
  logic [63:0] m_rdata;

  function automatic logic m_hit(int idx, logic [5:0] code, logic [3:0] ev);
    if (code == 6'h00) return 1'b1;
    if (code == 6'h01) return ev[0];
    if (code == 6'h09) return (idx == 0) ? ev[2] : ev[1];
    if (idx == 0 && code == 6'h1C) return ev[3];
    if (idx == 1 && code == 6'h14) return ev[3];
    return 1'b0;
  endfunction

  function automatic logic [63:0] m_view();
    logic [63:0] v = '0;
    v[0] = m_irq_en; v[1] = m_sup; v[2] = m_usr; v[3] = m_hyp;
    v[9:4] = m_sel[1]; v[16:11] = m_sel[0];
    v[17] = m_flag[1]; v[18] = m_flag[0];
    return v;
  endfunction

  function automatic logic [63:0] mk_ctrl(logic ie, logic sup, logic usr, logic hyp,
                                           logic [5:0] hi, logic [5:0] lo);
    logic [63:0] v = '0;
    v[0] = ie; v[1] = sup; v[2] = usr; v[3] = hyp;
    v[9:4] = lo; v[16:11] = hi;
    return v;
  endfunction

  always @(posedge clk) begin : model
    logic        ok;
    logic [63:0] pre_ctrl, pre_cnt;
    if (rst) begin
      for (int i = 0; i < 2; i++) begin
        m_cnt[i] = '0; m_sel[i] = '0; m_flag[i] = 1'b0;
      end
      {m_irq_en, m_sup, m_usr, m_hyp, m_irqo} = '0;
      m_rdata = '0;
    end else begin
      pre_ctrl = m_view();
      pre_cnt  = {m_cnt[0], m_cnt[1]};
      ok = (priv_lvl == 2'd0 && m_usr) || (priv_lvl == 2'd1 && m_sup) ||
           (priv_lvl == 2'd2 && m_hyp);
      for (int i = 0; i < 2; i++) begin
        logic setf, clrf;
        setf = 1'b0;
        if (reg_wr && reg_sel && reg_half[1-i])
          m_cnt[i] = (i == 0) ? reg_wdata[63:32] : reg_wdata[31:0];
        else if (ok && m_hit(i, m_sel[i], ev_in)) begin
          if (m_cnt[i] == 32'hFFFF_FFFF) setf = 1'b1;
          m_cnt[i] = m_cnt[i] + 32'd1;
        end
        clrf = reg_wr && !reg_sel && reg_wdata[(i == 0) ? 18 : 17];
        m_flag[i] = setf | (m_flag[i] & !clrf);
      end
      if (reg_wr && !reg_sel) begin
        m_irq_en = reg_wdata[0]; m_sup = reg_wdata[1];
        m_usr = reg_wdata[2]; m_hyp = reg_wdata[3];
        m_sel[1] = reg_wdata[9:4]; m_sel[0] = reg_wdata[16:11];
      end
      if (reg_rd) m_rdata = reg_sel ? pre_cnt : pre_ctrl;
      m_irqo = m_irq_en & (m_flag[0] | m_flag[1]);
    end
  end

  task automatic chk(string req, string what, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  // compare against the model on every clock
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(cur_req, "model irq", {63'd0, irq}, {63'd0, m_irqo});
      chk(cur_req, "model rdata", reg_rdata, m_rdata);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(logic sel, logic [1:0] half, logic [63:0] data);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_half = half; reg_wdata = data;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_expect(logic sel, logic [63:0] exp, string req);
    @(negedge clk);
    reg_rd = 1'b1; reg_sel = sel;
    @(negedge clk);
    reg_rd = 1'b0;
    chk(req, "read", reg_rdata, exp);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired in %s actual=running expected=finished", cur_req);
      finish_run();
    end
  end

  initial begin
    rst = 1'b1; reg_wr = 1'b0; reg_rd = 1'b0; reg_sel = 1'b0;
    reg_half = 2'b00; reg_wdata = '0; ev_in = '0; priv_lvl = 2'd0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    cur_req = "R1";
    chk("R1", "irq after reset", {63'd0, irq}, 64'd0);
    rd_expect(1'b0, 64'd0, "R1");
    rd_expect(1'b1, 64'd0, "R1");

    // R2: half writes, other half untouched
    cur_req = "R2";
    wr(1'b1, 2'b10, 64'hFFFF_FFFE_AAAA_AAAA);
    wr(1'b1, 2'b01, 64'hBBBB_BBBB_1234_5678);
    rd_expect(1'b1, 64'hFFFF_FFFE_1234_5678, "R2");

    // R8/R9: upper wraps after exactly two cycles; lower on idle code (R5)
    cur_req = "R8";
    wr(1'b0, 2'b00, mk_ctrl(1, 0, 1, 0, 6'h00, 6'h14));
    wr(1'b0, 2'b00, mk_ctrl(1, 0, 0, 0, 6'h00, 6'h14));
    chk("R9", "irq after wrap", {63'd0, irq}, 64'd1);
    rd_expect(1'b1, 64'h0000_0000_1234_5678, "R5");
    rd_expect(1'b0, mk_ctrl(1, 0, 0, 0, 6'h00, 6'h14) | 64'h4_0000, "R8");

    // R10: write one to clear
    cur_req = "R10";
    wr(1'b0, 2'b00, mk_ctrl(1, 0, 0, 0, 6'h00, 6'h14) | 64'h4_0000);
    chk("R10", "irq after clear", {63'd0, irq}, 64'd0);
    rd_expect(1'b0, mk_ctrl(1, 0, 0, 0, 6'h00, 6'h14), "R10");

    // R11: unused control bits read zero
    cur_req = "R11";
    wr(1'b0, 2'b00, '1);
    rd_expect(1'b0, 64'h0000_0000_0001_FBFF, "R11");
    wr(1'b0, 2'b00, 64'd0);

    // R3: cycles on upper, retired on lower
    cur_req = "R3";
    priv_lvl = 2'd0; ev_in = 4'b0000;
    wr(1'b0, 2'b00, mk_ctrl(0, 0, 1, 0, 6'h00, 6'h01));
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      ev_in = {3'b000, k[0]};
    end
    wr(1'b0, 2'b00, 64'd0);
    rd_expect(1'b1, 64'h0000_000E_1234_567F, "R3");

    // R4: code 0x09 splits by counter
    cur_req = "R4";
    ev_in = 4'b0010;
    wr(1'b0, 2'b00, mk_ctrl(0, 0, 1, 0, 6'h09, 6'h09));
    wr(1'b0, 2'b00, 64'd0);
    rd_expect(1'b1, 64'h0000_000E_1234_5681, "R4");
    ev_in = 4'b0100;
    wr(1'b0, 2'b00, mk_ctrl(0, 0, 1, 0, 6'h09, 6'h09));
    wr(1'b0, 2'b00, 64'd0);
    rd_expect(1'b1, 64'h0000_0010_1234_5681, "R4");

    // R5: idle codes count only the marker, and only on their own counter
    cur_req = "R5";
    ev_in = 4'b1000;
    wr(1'b0, 2'b00, mk_ctrl(0, 0, 1, 0, 6'h1C, 6'h14));
    wr(1'b0, 2'b00, 64'd0);
    rd_expect(1'b1, 64'h0000_0012_1234_5683, "R5");
    wr(1'b0, 2'b00, mk_ctrl(0, 0, 1, 0, 6'h14, 6'h1C));
    wr(1'b0, 2'b00, 64'd0);
    rd_expect(1'b1, 64'h0000_0012_1234_5683, "R5");

    // R6: shared context gating
    cur_req = "R6";
    priv_lvl = 2'd2;
    wr(1'b0, 2'b00, mk_ctrl(0, 0, 0, 1, 6'h00, 6'h00));
    wr(1'b0, 2'b00, 64'd0);
    rd_expect(1'b1, 64'h0000_0014_1234_5685, "R6");
    priv_lvl = 2'd1;
    wr(1'b0, 2'b00, mk_ctrl(0, 0, 0, 1, 6'h00, 6'h00));
    wr(1'b0, 2'b00, 64'd0);
    rd_expect(1'b1, 64'h0000_0014_1234_5685, "R6");
    wr(1'b0, 2'b00, mk_ctrl(0, 1, 0, 0, 6'h00, 6'h00));
    wr(1'b0, 2'b00, 64'd0);
    rd_expect(1'b1, 64'h0000_0016_1234_5687, "R6");
    priv_lvl = 2'd3;
    wr(1'b0, 2'b00, mk_ctrl(0, 1, 1, 1, 6'h00, 6'h00));
    wr(1'b0, 2'b00, 64'd0);
    rd_expect(1'b1, 64'h0000_0016_1234_5687, "R6");

    // R10: wrap in the same cycle as a clear keeps the flag
    cur_req = "R10";
    priv_lvl = 2'd0; ev_in = 4'b0000;
    wr(1'b1, 2'b10, 64'hFFFF_FFFF_0000_0000);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = mk_ctrl(1, 0, 1, 0, 6'h00, 6'h14);
    @(negedge clk);
    reg_wdata = mk_ctrl(1, 0, 1, 0, 6'h00, 6'h14) | 64'h4_0000;
    @(negedge clk);
    reg_wdata = mk_ctrl(1, 0, 0, 0, 6'h00, 6'h14);
    @(negedge clk);
    reg_wr = 1'b0;
    chk("R10", "irq kept by set", {63'd0, irq}, 64'd1);
    rd_expect(1'b0, mk_ctrl(1, 0, 0, 0, 6'h00, 6'h14) | 64'h4_0000, "R10");
    wr(1'b0, 2'b00, mk_ctrl(1, 0, 0, 0, 6'h00, 6'h00) | 64'h4_0000);

    // R7: write beats increment at 0xFFFFFFFF, no flag
    cur_req = "R7";
    wr(1'b0, 2'b00, mk_ctrl(1, 0, 1, 0, 6'h00, 6'h00));
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = 1'b1; reg_half = 2'b01; reg_wdata = 64'h0000_0000_FFFF_FFFF;
    @(negedge clk);
    reg_wdata = 64'h0000_0000_0000_0005;
    @(negedge clk);
    reg_sel = 1'b0; reg_wdata = mk_ctrl(1, 0, 0, 0, 6'h00, 6'h00);
    @(negedge clk);
    reg_wr = 1'b0;
    @(negedge clk);
    reg_rd = 1'b1; reg_sel = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    chk("R7", "lower after write collision", {32'd0, reg_rdata[31:0]}, 64'd6);
    rd_expect(1'b0, mk_ctrl(1, 0, 0, 0, 6'h00, 6'h00), "R7");
    chk("R7", "irq after write collision", {63'd0, irq}, 64'd0);

    // mixed random traffic, model compared every clock
    cur_req = "R9";
    for (int n = 0; n < 600; n++) begin
      int op;
      logic [5:0] codes [6];
      codes[0] = 6'h00; codes[1] = 6'h01; codes[2] = 6'h09;
      codes[3] = 6'h1C; codes[4] = 6'h14; codes[5] = 6'($urandom);
      @(negedge clk);
      reg_wr = 1'b0; reg_rd = 1'b0;
      ev_in = 4'($urandom);
      priv_lvl = 2'($urandom);
      op = $urandom % 10;
      if (op == 0) begin
        reg_wr = 1'b1; reg_sel = 1'b0;
        reg_wdata = {$urandom, $urandom};
        reg_wdata[16:11] = codes[$urandom % 6];
        reg_wdata[9:4]   = codes[$urandom % 6];
      end else if (op == 1) begin
        reg_wr = 1'b1; reg_sel = 1'b1; reg_half = 2'($urandom);
        reg_wdata = {28'hFFFF_FFF, 4'($urandom), 28'hFFFF_FFF, 4'($urandom)};
      end else if (op < 5) begin
        reg_rd = 1'b1; reg_sel = 1'($urandom);
      end
    end
    @(negedge clk);
    reg_wr = 1'b0; reg_rd = 1'b0;
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule